// File: doc/BRIEF.md
# Key-Locked IO Delay Configuration Register Bank

This block is a word-addressed register bank that holds the delay settings for a chip's IO pads. Each pad owns three consecutive delay registers. Every register carries a coarse element count and a fine element count, and those counts leave the block on flat output vectors that feed the delay lines. A bus master reads and writes the bank through a simple 32-bit port that has per-byte write strobes and a registered read path.

Three guards protect the delay region. The first is a global gate: it opens only when a 16-bit magic key is written, and it closes again when the lock key is written. The second is a signature: a delay write whose signature field is not the required constant is thrown away, and the block then raises a sticky error flag. The third is a per-register lock bit, which freezes that register's counts until a valid write clears the bit. Three calibration words are captured from a side port and are read-only to the bus. Any access above the last delay register reads zero and produces a one-cycle address-error pulse.

Top module: `dlykey_regbank`

## Requirements
- R1: After reset the gate is closed, the gate register reads 0x0000AAAB, every delay register reads zero, all coarse/fine outputs are zero, and sig_err and bus_addr_err are low.
- R2: The gate register sits at byte offset 0x2C. A write first merges its strobed bytes into the current low 16 bits. A merged value of 0xAAAA opens the gate, 0xAAAB closes it, and any other value leaves it unchanged. Reads return 0x0000AAAA when the gate is open and 0x0000AAAB when it is closed.
- R3: While the gate is closed, writes to delay registers leave them unchanged, and reads still return the stored values.
- R4: A delay write whose merged bits 17:12 are not 0x29 is discarded and sets sig_err. sig_err stays high until reset.
- R5: The delay word layout is bits 17:12 signature, bit 10 register lock, bits 9:5 coarse count and bits 4:0 fine count. A read returns 0x29 in the signature field once a valid write has been accepted, and zero in every other unused bit.
- R6: A register whose lock bit is 1 ignores valid writes that keep bit 10 at 1. A valid write with bit 10 at 0 clears only the lock bit and keeps the counts. Later writes then apply in full.
- R7: Byte strobes bus_wstrb[b] select byte b of bus_wdata. Bytes that are not strobed keep the stored content, and the signature check runs on the merged word.
- R8: Pulsing cal_load captures the three calibration inputs. Offset 0x14 returns the reference period in bits 15:0 with zero above. Offset 0x18 returns the coarse word and offset 0x1C returns the fine word. Bus writes to these offsets have no effect.
- R9: Delay register k sits at byte offset 0x30+4k, so pad p owns k=3p..3p+2, and the last one is at 0xD1C. Its counts appear on pin_coarse[5k+:5] and pin_fine[5k+:5]. Address bits 1:0 are ignored. Unmapped offsets below 0x30 read zero.
- R10: A read or write above 0xD1C returns zero on a read, changes no state, and pulses bus_addr_err for exactly the cycle after the access. In-range accesses never raise it.
- R11: bus_rdata updates on the clock edge that samples bus_rd and holds its value while bus_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Per-byte write enables |
| bus_rdata | output | 32 | Registered read data |
| bus_addr_err | output | 1 | One-cycle pulse after an out-of-range access |
| cal_load | input | 1 | Capture strobe for calibration inputs |
| cal_ref_period | input | 16 | Reference clock period |
| cal_coarse_word | input | 32 | Coarse calibration (delay count 31:16, reference count 15:0) |
| cal_fine_word | input | 32 | Fine calibration (same layout) |
| sig_err | output | 1 | Sticky signature-mismatch flag |
| pin_coarse | output | 4140 | Coarse counts, 5 bits per delay register |
| pin_fine | output | 4140 | Fine counts, 5 bits per delay register |

## Verification
The bench aims at the interaction between the gate, the signature and the per-register lock.

- A write while the gate is closed must not land. A design that gated it wrongly would let a delay value through.
- A partial-byte write must be merged before the signature is checked. A design that checked the raw write data would either reject a valid low-byte update or accept a write that destroys the signature.
- A locked register must let a lock-clearing write keep its counts. A design that got this wrong would overwrite or zero them.
- The first and last delay registers and the first address past the end are probed. An off-by-one in decode would alias 0xD20 onto a real register or miss 0xD1C.
- The key is also written one byte at a time, to catch a gate that compares raw write data instead of the merged value.

// File: rtl/dlykey_pkg.sv
package dlykey_pkg;

  // delay word field positions (decoded by the delay lines downstream)
  localparam int unsigned SIG_LSB  = 12;
  localparam int unsigned SIG_W    = 6;
  localparam logic [5:0]  SIG_VAL  = 6'h29;
  localparam int unsigned LOCK_BIT = 10;
  localparam int unsigned CO_LSB   = 5;
  localparam int unsigned CO_W     = 5;
  localparam int unsigned FI_LSB   = 0;
  localparam int unsigned FI_W     = 5;

  // gate key values
  localparam logic [15:0] KEY_OPEN = 16'hAAAA;
  localparam logic [15:0] KEY_SHUT = 16'hAAAB;

  // fixed byte offsets of the calibration and gate words
  localparam int unsigned OFS_REF  = 32'h14;
  localparam int unsigned OFS_CRS  = 32'h18;
  localparam int unsigned OFS_FIN  = 32'h1C;
  localparam int unsigned OFS_KEY  = 32'h2C;

  typedef enum logic [2:0] {
    RGN_NONE,
    RGN_REF,
    RGN_CRS,
    RGN_FIN,
    RGN_KEY,
    RGN_PIN
  } rgn_t;

  typedef struct packed {
    logic            sig_ok;
    logic            lock;
    logic [CO_W-1:0] coarse;
    logic [FI_W-1:0] fine;
  } pin_cfg_t;

  function automatic logic [31:0] cfg_to_word(input pin_cfg_t c);
    logic [31:0] w;
    w = '0;
    if (c.sig_ok) w[SIG_LSB +: SIG_W] = SIG_VAL;
    w[LOCK_BIT]          = c.lock;
    w[CO_LSB +: CO_W]    = c.coarse;
    w[FI_LSB +: FI_W]    = c.fine;
    return w;
  endfunction

  function automatic logic [31:0] strb_to_mask(input logic [3:0] s);
    logic [31:0] m;
    for (int b = 0; b < 4; b++) m[b*8 +: 8] = {8{s[b]}};
    return m;
  endfunction

endpackage

// File: rtl/dlykey_decode.sv
module dlykey_decode
  import dlykey_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned PIN_BASE = 32'h30,
  parameter int unsigned PIN_LAST = 32'hD1C
) (
  input  logic [ADDR_W-1:0] addr,
  output rgn_t              rgn,
  output logic [ADDR_W-3:0] pin_idx,
  output logic              beyond
);

  localparam int unsigned WW = ADDR_W - 2;
  localparam logic [WW-1:0] W_BASE = WW'(PIN_BASE / 4);
  localparam logic [WW-1:0] W_LAST = WW'(PIN_LAST / 4);
  localparam logic [WW-1:0] W_REF  = WW'(OFS_REF / 4);
  localparam logic [WW-1:0] W_CRS  = WW'(OFS_CRS / 4);
  localparam logic [WW-1:0] W_FIN  = WW'(OFS_FIN / 4);
  localparam logic [WW-1:0] W_KEY  = WW'(OFS_KEY / 4);

  logic [WW-1:0] word;

  assign word    = addr[ADDR_W-1:2];
  assign pin_idx = word - W_BASE;
  assign beyond  = addr > ADDR_W'(PIN_LAST);

  always_comb begin
    rgn = RGN_NONE;
    if (!beyond) begin
      if (word >= W_BASE && word <= W_LAST) begin
        rgn = RGN_PIN;
      end else begin
        unique case (word)
          W_REF:   rgn = RGN_REF;
          W_CRS:   rgn = RGN_CRS;
          W_FIN:   rgn = RGN_FIN;
          W_KEY:   rgn = RGN_KEY;
          default: rgn = RGN_NONE;
        endcase
      end
    end
  end

endmodule

// File: rtl/dlykey_gate.sv
module dlykey_gate
  import dlykey_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wdata,
  input  logic [1:0]  wstrb,
  output logic        locked
);

  logic [15:0] cur_key;
  logic [15:0] merged;
  logic        locked_d;

  always_comb begin
    cur_key = locked ? KEY_SHUT : KEY_OPEN;
    merged[7:0]  = wstrb[0] ? wdata[7:0]  : cur_key[7:0];
    merged[15:8] = wstrb[1] ? wdata[15:8] : cur_key[15:8];
    locked_d = locked;
    if (wr_en) begin
      if (merged == KEY_OPEN)      locked_d = 1'b0;
      else if (merged == KEY_SHUT) locked_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) locked <= 1'b1;
    else        locked <= locked_d;
  end

endmodule

// File: rtl/dlykey_pinwrite.sv
module dlykey_pinwrite
  import dlykey_pkg::*;
(
  input  pin_cfg_t    cur,
  input  logic [31:0] wdata,
  input  logic [3:0]  wstrb,
  output logic        upd_en,
  output pin_cfg_t    upd_cfg,
  output logic        sig_bad
);

  logic [31:0] mask;
  logic [31:0] merged;

  always_comb begin
    mask    = strb_to_mask(wstrb);
    merged  = (cfg_to_word(cur) & ~mask) | (wdata & mask);
    sig_bad = merged[SIG_LSB +: SIG_W] != SIG_VAL;
    upd_en  = 1'b0;
    upd_cfg = cur;
    if (!sig_bad) begin
      if (cur.lock) begin
        // a frozen register only accepts the lock release, counts kept
        if (!merged[LOCK_BIT]) begin
          upd_en       = 1'b1;
          upd_cfg.lock = 1'b0;
        end
      end else begin
        upd_en         = 1'b1;
        upd_cfg.sig_ok = 1'b1;
        upd_cfg.lock   = merged[LOCK_BIT];
        upd_cfg.coarse = merged[CO_LSB +: CO_W];
        upd_cfg.fine   = merged[FI_LSB +: FI_W];
      end
    end
  end

endmodule

// File: rtl/dlykey_cell.sv
module dlykey_cell
  import dlykey_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ld,
  input  pin_cfg_t d,
  output pin_cfg_t q
);

  pin_cfg_t q_d;

  always_comb q_d = ld ? d : q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end

endmodule

// File: rtl/dlykey_regbank.sv
module dlykey_regbank
  import dlykey_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned PIN_BASE = 32'h30,
  parameter int unsigned PIN_LAST = 32'hD1C,
  localparam int unsigned NUM_REGS = (PIN_LAST - PIN_BASE) / 4 + 1,
  localparam int unsigned OUT_W    = NUM_REGS * CO_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic               bus_rd,
  input  logic [31:0]        bus_wdata,
  input  logic [3:0]         bus_wstrb,
  output logic [31:0]        bus_rdata,
  output logic               bus_addr_err,
  input  logic               cal_load,
  input  logic [15:0]        cal_ref_period,
  input  logic [31:0]        cal_coarse_word,
  input  logic [31:0]        cal_fine_word,
  output logic               sig_err,
  output logic [OUT_W-1:0]   pin_coarse,
  output logic [OUT_W-1:0]   pin_fine
);

  localparam int unsigned IDX_W = ADDR_W - 2;

  rgn_t             rgn;
  logic [IDX_W-1:0] pin_idx;
  logic             beyond;
  logic             key_locked;
  logic             pin_fire;
  logic             upd_en;
  logic             sig_bad;
  pin_cfg_t         upd_cfg;
  pin_cfg_t         sel_cfg;
  pin_cfg_t         cell_q [NUM_REGS];

  logic [15:0] cal_ref_q,  cal_ref_d;
  logic [31:0] cal_crs_q,  cal_crs_d;
  logic [31:0] cal_fin_q,  cal_fin_d;
  logic [31:0] rdata_d;
  logic        aerr_d;
  logic        sig_err_d;

  dlykey_decode #(
    .ADDR_W  (ADDR_W),
    .PIN_BASE(PIN_BASE),
    .PIN_LAST(PIN_LAST)
  ) u_decode (
    .addr   (bus_addr),
    .rgn    (rgn),
    .pin_idx(pin_idx),
    .beyond (beyond)
  );

  dlykey_gate u_gate (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (bus_we && rgn == RGN_KEY),
    .wdata (bus_wdata[15:0]),
    .wstrb (bus_wstrb[1:0]),
    .locked(key_locked)
  );

  always_comb sel_cfg = (32'(pin_idx) < NUM_REGS) ? cell_q[pin_idx] : '0;

  dlykey_pinwrite u_pinwrite (
    .cur    (sel_cfg),
    .wdata  (bus_wdata),
    .wstrb  (bus_wstrb),
    .upd_en (upd_en),
    .upd_cfg(upd_cfg),
    .sig_bad(sig_bad)
  );

  assign pin_fire = bus_we && rgn == RGN_PIN && !key_locked;

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_cell
    dlykey_cell u_cell (
      .clk  (clk),
      .rst_n(rst_n),
      .ld   (pin_fire && upd_en && pin_idx == IDX_W'(gi)),
      .d    (upd_cfg),
      .q    (cell_q[gi])
    );
    assign pin_coarse[gi*CO_W +: CO_W] = cell_q[gi].coarse;
    assign pin_fine[gi*FI_W +: FI_W]   = cell_q[gi].fine;
  end

  // next-state logic
  always_comb begin
    cal_ref_d = cal_load ? cal_ref_period  : cal_ref_q;
    cal_crs_d = cal_load ? cal_coarse_word : cal_crs_q;
    cal_fin_d = cal_load ? cal_fine_word   : cal_fin_q;
    sig_err_d = sig_err || (pin_fire && sig_bad);
    aerr_d    = (bus_we || bus_rd) && beyond;
    rdata_d   = bus_rdata;
    if (bus_rd) begin
      unique case (rgn)
        RGN_REF: rdata_d = {16'h0, cal_ref_q};
        RGN_CRS: rdata_d = cal_crs_q;
        RGN_FIN: rdata_d = cal_fin_q;
        RGN_KEY: rdata_d = {16'h0, key_locked ? KEY_SHUT : KEY_OPEN};
        RGN_PIN: rdata_d = cfg_to_word(sel_cfg);
        default: rdata_d = '0;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_ref_q    <= '0;
      cal_crs_q    <= '0;
      cal_fin_q    <= '0;
      sig_err      <= 1'b0;
      bus_addr_err <= 1'b0;
      bus_rdata    <= '0;
    end else begin
      cal_ref_q    <= cal_ref_d;
      cal_crs_q    <= cal_crs_d;
      cal_fin_q    <= cal_fin_d;
      sig_err      <= sig_err_d;
      bus_addr_err <= aerr_d;
      bus_rdata    <= rdata_d;
    end
  end

endmodule

// File: rtl/dlykey_regbank_chk.sv
module dlykey_regbank_chk #(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned PIN_LAST = 32'hD1C,
  parameter int unsigned OUT_W    = 4140
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic              bus_rd,
  input logic [31:0]       bus_rdata,
  input logic              bus_addr_err,
  input logic              sig_err,
  input logic              key_locked,
  input logic [OUT_W-1:0]  pin_coarse,
  input logic [OUT_W-1:0]  pin_fine
);

  logic far_access;
  assign far_access = (bus_we || bus_rd) && (bus_addr > ADDR_W'(PIN_LAST));

  assert_locked_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
    key_locked |=> ($stable(pin_coarse) && $stable(pin_fine)));

  assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sig_err |=> sig_err);

  assert_far_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    far_access |=> bus_addr_err);

  assert_no_stray_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !far_access |=> !bus_addr_err);

  assert_far_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr > ADDR_W'(PIN_LAST)) |=> (bus_rdata == 32'h0));

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

endmodule

bind dlykey_regbank dlykey_regbank_chk #(
  .ADDR_W  (ADDR_W),
  .PIN_LAST(PIN_LAST),
  .OUT_W   (OUT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_addr    (bus_addr),
  .bus_we      (bus_we),
  .bus_rd      (bus_rd),
  .bus_rdata   (bus_rdata),
  .bus_addr_err(bus_addr_err),
  .sig_err     (sig_err),
  .key_locked  (key_locked),
  .pin_coarse  (pin_coarse),
  .pin_fine    (pin_fine)
);

// File: tb/dlykey_regbank_bench.sv
module dlykey_regbank_bench;

  localparam int unsigned NREG = 828;
  localparam int unsigned OW   = NREG * 5;

  logic          clk;
  logic          rst_n;
  logic [11:0]   bus_addr;
  logic          bus_we;
  logic          bus_rd;
  logic [31:0]   bus_wdata;
  logic [3:0]    bus_wstrb;
  logic [31:0]   bus_rdata;
  logic          bus_addr_err;
  logic          cal_load;
  logic [15:0]   cal_ref_period;
  logic [31:0]   cal_coarse_word;
  logic [31:0]   cal_fine_word;
  logic          sig_err;
  logic [OW-1:0] pin_coarse;
  logic [OW-1:0] pin_fine;

  int  n_checks;
  int  n_errors;
  bit  done;

  dlykey_regbank u_dlykey_regbank (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_addr       (bus_addr),
    .bus_we         (bus_we),
    .bus_rd         (bus_rd),
    .bus_wdata      (bus_wdata),
    .bus_wstrb      (bus_wstrb),
    .bus_rdata      (bus_rdata),
    .bus_addr_err   (bus_addr_err),
    .cal_load       (cal_load),
    .cal_ref_period (cal_ref_period),
    .cal_coarse_word(cal_coarse_word),
    .cal_fine_word  (cal_fine_word),
    .sig_err        (sig_err),
    .pin_coarse     (pin_coarse),
    .pin_fine       (pin_fine)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic        we;
    logic        rd;
    logic [11:0] addr;
    logic [31:0] wd;
    logic [3:0]  st;
    logic [31:0] exp;
    logic        aerr;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b1,12'h02C,32'h0,      4'h0,32'h0000AAAB,1'b0,4'd2},  // R2 closed at start
    '{1'b1,1'b0,12'h030,32'h29067,  4'hF,32'h0,       1'b0,4'd3},  // R3 write while closed
    '{1'b0,1'b1,12'h030,32'h0,      4'h0,32'h0,       1'b0,4'd3},
    '{1'b1,1'b0,12'h02C,32'h0000AAAA,4'h3,32'h0,      1'b0,4'd2},  // R2 open
    '{1'b0,1'b1,12'h02C,32'h0,      4'h0,32'h0000AAAA,1'b0,4'd2},
    '{1'b1,1'b0,12'h030,32'h29067,  4'hF,32'h0,       1'b0,4'd5},  // R5 coarse 3 fine 7
    '{1'b0,1'b1,12'h030,32'h0,      4'h0,32'h00029067,1'b0,4'd5},
    '{1'b1,1'b0,12'h034,32'h2801F,  4'hF,32'h0,       1'b0,4'd4},  // R4 bad signature
    '{1'b0,1'b1,12'h034,32'h0,      4'h0,32'h0,       1'b0,4'd4},
    '{1'b1,1'b0,12'hD1C,32'h297E1,  4'hF,32'h0,       1'b0,4'd6},  // R6 set own lock
    '{1'b0,1'b1,12'hD1C,32'h0,      4'h0,32'h000297E1,1'b0,4'd6},
    '{1'b1,1'b0,12'hD1C,32'h29421,  4'hF,32'h0,       1'b0,4'd6},  // R6 ignored
    '{1'b0,1'b1,12'hD1C,32'h0,      4'h0,32'h000297E1,1'b0,4'd6},
    '{1'b1,1'b0,12'hD1C,32'h29000,  4'hF,32'h0,       1'b0,4'd6},  // R6 release only
    '{1'b0,1'b1,12'hD1C,32'h0,      4'h0,32'h000293E1,1'b0,4'd6},
    '{1'b1,1'b0,12'hD1C,32'h29005,  4'hF,32'h0,       1'b0,4'd6},  // R6 full write again
    '{1'b0,1'b1,12'hD1C,32'h0,      4'h0,32'h00029005,1'b0,4'd6},
    '{1'b1,1'b0,12'h030,32'h000000E2,4'h1,32'h0,      1'b0,4'd7},  // R7 low byte merge
    '{1'b0,1'b1,12'h030,32'h0,      4'h0,32'h000290E2,1'b0,4'd7},
    '{1'b1,1'b0,12'h030,32'h0,      4'h4,32'h0,       1'b0,4'd7},  // R7 merge breaks sig
    '{1'b0,1'b1,12'h030,32'h0,      4'h0,32'h000290E2,1'b0,4'd7},
    '{1'b0,1'b1,12'hD20,32'h0,      4'h0,32'h0,       1'b1,4'd10}, // R10 past end
    '{1'b1,1'b0,12'h02C,32'h000000AB,4'h1,32'h0,      1'b0,4'd2},  // R2 byte-wise close
    '{1'b0,1'b1,12'h02C,32'h0,      4'h0,32'h0000AAAB,1'b0,4'd2},
    '{1'b1,1'b0,12'h030,32'h29000,  4'hF,32'h0,       1'b0,4'd3},  // R3 dropped
    '{1'b0,1'b1,12'h030,32'h0,      4'h0,32'h000290E2,1'b0,4'd3},
    '{1'b1,1'b0,12'h02C,32'h00001234,4'h3,32'h0,      1'b0,4'd2},  // R2 other value
    '{1'b0,1'b1,12'h02C,32'h0,      4'h0,32'h0000AAAB,1'b0,4'd2},
    '{1'b0,1'b1,12'h032,32'h0,      4'h0,32'h000290E2,1'b0,4'd9},  // R9 low bits ignored
    '{1'b0,1'b1,12'h010,32'h0,      4'h0,32'h0,       1'b0,4'd9}   // R9 unmapped
  };

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic we, input logic rd, input logic [11:0] a,
                     input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    bus_we = we; bus_rd = rd; bus_addr = a; bus_wdata = d; bus_wstrb = s;
    @(negedge clk);
    bus_we = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    n_checks = 0; n_errors = 0; done = 1'b0;
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_rd = 1'b0;
    bus_wdata = '0; bus_wstrb = '0; cal_load = 1'b0;
    cal_ref_period = '0; cal_coarse_word = '0; cal_fine_word = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 sig_err", {31'h0, sig_err}, 32'h0);
    chk("R1 addr_err", {31'h0, bus_addr_err}, 32'h0);
    chk("R1 coarse all zero", {31'h0, |pin_coarse}, 32'h0);
    chk("R1 fine all zero", {31'h0, |pin_fine}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      acc(VEC[i].we, VEC[i].rd, VEC[i].addr, VEC[i].wd, VEC[i].st);
      if (VEC[i].rd)
        chk($sformatf("R%0d row %0d rdata", VEC[i].req, i), bus_rdata, VEC[i].exp);
      chk($sformatf("R%0d row %0d addr_err", VEC[i].req, i),
          {31'h0, bus_addr_err}, {31'h0, VEC[i].aerr});
    end

    // R5 outputs of register 0: coarse 7, fine 2
    chk("R5 reg0 coarse out", {27'h0, pin_coarse[4:0]}, 32'd7);
    chk("R5 reg0 fine out", {27'h0, pin_fine[4:0]}, 32'd2);
    // R9 last register outputs
    chk("R9 last reg fine out", {27'h0, pin_fine[(NREG-1)*5 +: 5]}, 32'd5);
    chk("R9 last reg coarse out", {27'h0, pin_coarse[(NREG-1)*5 +: 5]}, 32'd0);
    // R4 sticky flag
    chk("R4 sig_err sticky", {31'h0, sig_err}, 32'h1);

    // R9 third register of pad 0 maps to output slot 2
    acc(1'b1, 1'b0, 12'h02C, 32'h0000AAAA, 4'h3);
    acc(1'b1, 1'b0, 12'h038, 32'h00029124, 4'hF);
    chk("R9 slot2 coarse", {27'h0, pin_coarse[10 +: 5]}, 32'd9);
    chk("R9 slot2 fine", {27'h0, pin_fine[10 +: 5]}, 32'd4);
    chk("R9 slot1 untouched", {27'h0, pin_coarse[5 +: 5]}, 32'd0);

    // R10 write past the end
    acc(1'b1, 1'b0, 12'hD20, 32'h00029000, 4'hF);
    chk("R10 write addr_err", {31'h0, bus_addr_err}, 32'h1);
    acc(1'b0, 1'b1, 12'hD1C, 32'h0, 4'h0);
    chk("R10 no alias onto last", bus_rdata, 32'h00029005);
    chk("R10 pulse one cycle", {31'h0, bus_addr_err}, 32'h0);

    // R8 calibration capture
    @(negedge clk);
    cal_ref_period = 16'h1234; cal_coarse_word = 32'h00580123;
    cal_fine_word = 32'h00AB0CDE; cal_load = 1'b1;
    @(negedge clk);
    cal_load = 1'b0; cal_ref_period = 16'hFFFF;
    acc(1'b0, 1'b1, 12'h014, 32'h0, 4'h0);
    chk("R8 ref period", bus_rdata, 32'h00001234);
    acc(1'b0, 1'b1, 12'h018, 32'h0, 4'h0);
    chk("R8 coarse word", bus_rdata, 32'h00580123);
    acc(1'b0, 1'b1, 12'h01C, 32'h0, 4'h0);
    chk("R8 fine word", bus_rdata, 32'h00AB0CDE);
    acc(1'b1, 1'b0, 12'h018, 32'hFFFFFFFF, 4'hF);
    acc(1'b0, 1'b1, 12'h018, 32'h0, 4'h0);
    chk("R8 write ignored", bus_rdata, 32'h00580123);

    // R11 rdata holds without a read strobe
    acc(1'b0, 1'b0, 12'h030, 32'h0, 4'h0);
    chk("R11 rdata hold", bus_rdata, 32'h00580123);

    // R1 reset in mid-run
    do_reset();
    @(negedge clk);
    chk("R1 sig_err cleared", {31'h0, sig_err}, 32'h0);
    chk("R1 outputs cleared", {31'h0, |pin_coarse | |pin_fine}, 32'h0);
    acc(1'b0, 1'b1, 12'h02C, 32'h0, 4'h0);
    chk("R1 gate closed", bus_rdata, 32'h0000AAAB);
    acc(1'b0, 1'b1, 12'h038, 32'h0, 4'h0);
    chk("R1 delay reg zero", bus_rdata, 32'h0);

    done = 1'b1;
    finish_run();
  end

endmodule